// File: doc/BRIEF.md
# Wake Source Controller

This block sits in the always-on domain and watches a set of wake sources while the rest of the chip sleeps or only drives the display. When an enabled source meets its trigger rule, the block latches a flag for that source and raises a request that the power sequencer uses to move the chip into the battery-run state. The processor, once running, reads the flags to learn why it woke. It then clears them by writing ones to a clear mask.

The external sources are a wake timer expiry pulse, a pushbutton, the serial receive pin and three general pins (A, B and C). Each source has its own rule: a single-cycle pulse, either edge, a rising edge, or a high level that must hold across a number of sampling ticks. Pin C switches between an either-edge rule and a debounced high-level rule on a configuration input. Four internal causes (power-on, error reset, counter overflow, bad supply) always latch a flag, whatever the enable and arm state. Asynchronous pins pass through a two-stage synchronizer. The sampling tick, one pulse per 2 ms in a real system, is supplied from outside, and `HOLD` ticks (32, for 64 ms) qualify a level.

Top module: `wake_ctrl`

## Requirements
- R1: After reset, flags, enables, arm and `wake_req` are all 0.
- R2: A timer expiry pulse sets flag bit 0 when enable bit 0 and arm are 1.
- R3: Either edge on `rx_pin` sets flag bit 2 when enable bit 2 and arm are 1.
- R4: A rising edge on `pin_a` sets flag bit 3. A falling edge does not set it.
- R5: `btn_pin` (flag bit 1), `pin_b` (flag bit 4) and `pin_c` in level mode (flag bit 5) set their flag only after `HOLD` consecutive ticks sample them high. A tick that samples low restarts the count.
- R6: With `opt_rxdis`=0, either edge on `pin_c` sets flag bit 5. With `opt_rxdis`=1, the debounced high level of R5 sets it.
- R7: An external source whose bit in `en_q` is 0 never sets its flag. `cfg_en` bit i gates flag bit i for i in 0..5.
- R8: While `arm_q` is 0, no external source sets a flag.
- R9: A pulse on `fixed_ev[k]` sets flag bit 6+k regardless of enables and arm.
- R10: Flags stay set until a 1 is written at the same position of `flag_clr`. Clear bits at other positions have no effect.
- R11: `wake_req` is 1 exactly when some set flag in bits 6..9 exists, or some set flag in bits 0..5 has its enable bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Debounce sampling strobe |
| timer_fire | input | 1 | Wake timer expiry pulse (synchronous) |
| btn_pin | input | 1 | Pushbutton, asynchronous |
| rx_pin | input | 1 | Serial receive pin, asynchronous |
| pin_a | input | 1 | General pin A, rising edge rule |
| pin_b | input | 1 | General pin B, debounced level rule |
| pin_c | input | 1 | General pin C, rule set by `opt_rxdis` |
| opt_rxdis | input | 1 | 1 = level mode for pin C, 0 = either-edge mode |
| fixed_ev | input | 4 | Always-enabled internal cause pulses |
| cfg_we | input | 1 | Write strobe for enables and arm |
| cfg_en | input | 6 | Enable bits, bit i gates flag i |
| cfg_arm | input | 1 | Arm bit value |
| flag_clr | input | 10 | Write-one-to-clear mask for flags |
| en_q | output | 6 | Current enable bits |
| arm_q | output | 1 | Current arm bit |
| flags | output | 10 | Wake flags |
| wake_req | output | 1 | Request to enter battery-run state |

## Verification
A debounce counter that drifts shows at the ports as a level flag that rises a tick early or late, or that fails to restart after a low sample. The sweep catches this on the tick that should or should not complete the hold. A wrong edge register or mode mux shows within three cycles of the pin change, as a missing or extra flag. A gating fault in the enable or arm path shows in the same window, because the sweep tries every enable and arm combination for every source. A flag that does not stay set, or a wrong request gate, shows on `flags` or `wake_req` in the cycle after the clear or the enable write.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int N_EXT  = 6;
    localparam int N_FIX  = 4;
    localparam int N_FLAG = N_EXT + N_FIX;
    localparam int N_PIN  = 5;
    localparam int N_LVL  = 3;

    // flag positions (software-visible)
    localparam int F_TMR = 0;
    localparam int F_BTN = 1;
    localparam int F_RX  = 2;
    localparam int F_PA  = 3;
    localparam int F_PB  = 4;
    localparam int F_PC  = 5;

    // synchronizer lane positions
    localparam int P_BTN = 0;
    localparam int P_RX  = 1;
    localparam int P_PA  = 2;
    localparam int P_PB  = 3;
    localparam int P_PC  = 4;

    typedef struct packed {
        logic [N_EXT-1:0]  en;
        logic              arm;
        logic [N_FLAG-1:0] flags;
        logic              prev_rx;
        logic              prev_pa;
        logic              prev_pc;
    } wake_st_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] lvl;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.lvl  = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    // two-stage delay: the output follows the first stage one cycle later
    a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl_o == $past(st_q.meta)));
endmodule

// File: rtl/wake_debounce.sv
module wake_debounce #(
    parameter int HOLD = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lvl_i,
    output logic held_o
);
    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } db_st_t;

    db_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (!lvl_i)
                st_d.cnt = '0;
            else if (st_q.cnt != CNT_MAX)
                st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o = (st_q.cnt == CNT_MAX);

    a_r5_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !lvl_i) |=> (st_q.cnt == '0) && !held_o);

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt));
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
    import wake_pkg::*;
#(
    parameter int HOLD = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              timer_fire,
    input  logic              btn_pin,
    input  logic              rx_pin,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              pin_c,
    input  logic              opt_rxdis,
    input  logic [N_FIX-1:0]  fixed_ev,
    input  logic              cfg_we,
    input  logic [N_EXT-1:0]  cfg_en,
    input  logic              cfg_arm,
    input  logic [N_FLAG-1:0] flag_clr,
    output logic [N_EXT-1:0]  en_q,
    output logic              arm_q,
    output logic [N_FLAG-1:0] flags,
    output logic              wake_req
);
    logic [N_PIN-1:0] pin_raw;
    logic [N_PIN-1:0] pin_lvl;
    logic [N_LVL-1:0] lvl_in;
    logic [N_LVL-1:0] held;
    logic [N_EXT-1:0] hit;
    logic [N_EXT-1:0] gated;
    wake_st_t         st_d, st_q;

    assign pin_raw = {pin_c, pin_b, pin_a, rx_pin, btn_pin};

    wake_sync #(.W(N_PIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_raw),
        .lvl_o (pin_lvl)
    );

    // level-qualified lanes: 0 = button, 1 = pin B, 2 = pin C
    assign lvl_in = {pin_lvl[P_PC], pin_lvl[P_PB], pin_lvl[P_BTN]};

    for (genvar g = 0; g < N_LVL; g++) begin : g_db
        wake_debounce #(.HOLD(HOLD)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .lvl_i  (lvl_in[g]),
            .held_o (held[g])
        );
    end

    always_comb begin
        hit        = '0;
        hit[F_TMR] = timer_fire;
        hit[F_BTN] = held[0];
        hit[F_RX]  = pin_lvl[P_RX] ^ st_q.prev_rx;
        hit[F_PA]  = pin_lvl[P_PA] & ~st_q.prev_pa;
        hit[F_PB]  = held[1];
        hit[F_PC]  = opt_rxdis ? held[2] : (pin_lvl[P_PC] ^ st_q.prev_pc);
        gated      = hit & st_q.en & {N_EXT{st_q.arm}};

        st_d         = st_q;
        st_d.prev_rx = pin_lvl[P_RX];
        st_d.prev_pa = pin_lvl[P_PA];
        st_d.prev_pc = pin_lvl[P_PC];
        if (cfg_we) begin
            st_d.en  = cfg_en;
            st_d.arm = cfg_arm;
        end
        // a new event outranks a clear in the same cycle
        st_d.flags = (st_q.flags & ~flag_clr) | {fixed_ev, gated};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q     = st_q.en;
    assign arm_q    = st_q.arm;
    assign flags    = st_q.flags;
    assign wake_req = |(st_q.flags & {{N_FIX{1'b1}}, st_q.en});

    a_r8_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_q |=> ((flags[N_EXT-1:0] & ~$past(flags[N_EXT-1:0])) == '0));

    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags[N_EXT-1:0] & ~$past(flags[N_EXT-1:0]) & ~$past(en_q)) == '0));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

    a_r9_fixed_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_ev != '0) |=> ((flags[N_FLAG-1:N_EXT] & $past(fixed_ev)) == $past(fixed_ev)));

    a_r11_fixed_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[N_FLAG-1:N_EXT] != '0) |-> wake_req);
endmodule

// File: tb/wake_ctrl_test.sv
module wake_ctrl_test;
    localparam int HOLD = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       timer_fire = 1'b0;
    logic       btn_pin = 1'b0;
    logic       rx_pin = 1'b0;
    logic       pin_a = 1'b0;
    logic       pin_b = 1'b0;
    logic       pin_c = 1'b0;
    logic       opt_rxdis = 1'b0;
    logic [3:0] fixed_ev = '0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_en = '0;
    logic       cfg_arm = 1'b0;
    logic [9:0] flag_clr = '0;
    logic [5:0] en_q;
    logic       arm_q;
    logic [9:0] flags;
    logic       wake_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wake_ctrl #(.HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .timer_fire(timer_fire),
        .btn_pin(btn_pin), .rx_pin(rx_pin), .pin_a(pin_a), .pin_b(pin_b),
        .pin_c(pin_c), .opt_rxdis(opt_rxdis), .fixed_ev(fixed_ev),
        .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_arm(cfg_arm),
        .flag_clr(flag_clr), .en_q(en_q), .arm_q(arm_q), .flags(flags),
        .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tk();
        tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
    endtask

    task automatic cfg(input logic [5:0] e, input logic a);
        cfg_we = 1'b1; cfg_en = e; cfg_arm = a; cyc(1);
        cfg_we = 1'b0; cyc(1);
    endtask

    task automatic clr(input logic [9:0] m);
        flag_clr = m; cyc(1); flag_clr = '0; cyc(1);
    endtask

    task automatic fire(input int s);
        case (s)
            0: begin timer_fire = 1'b1; cyc(1); timer_fire = 1'b0; cyc(3); end
            1: begin btn_pin = 1'b1; cyc(4); repeat (HOLD) tk(); cyc(3); end
            2: begin rx_pin = ~rx_pin; cyc(5); end
            3: begin pin_a = 1'b1; cyc(5); end
            4: begin pin_b = 1'b1; cyc(4); repeat (HOLD) tk(); cyc(3); end
            default: begin
                pin_c = 1'b1; cyc(4);
                if (opt_rxdis) repeat (HOLD) tk();
                cyc(3);
            end
        endcase
    endtask

    task automatic idle();
        btn_pin = 1'b0; pin_a = 1'b0; pin_b = 1'b0; pin_c = 1'b0;
        cyc(4); tk(); cyc(3);
        clr('1);
    endtask

    function automatic string src_tag(input int s, input bit m);
        case (s)
            0: return "R2";
            1: return "R5";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return m ? "R6 level R5" : "R6 edge";
        endcase
    endfunction

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk("R1 flags", 32'(flags), 0);
        chk("R1 en", 32'(en_q), 0);
        chk("R1 arm", 32'(arm_q), 0);
        chk("R1 wake_req", 32'(wake_req), 0);

        // sweep: mode x source x enable x arm (R7, R8)
        for (int m = 0; m < 2; m++) begin
            opt_rxdis = m[0];
            for (int s = 0; s < 6; s++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int a = 0; a < 2; a++) begin
                        logic [5:0] ev;
                        logic [9:0] exp;
                        ev  = (e != 0) ? 6'h3f : ~(6'(1) << s);
                        exp = (e != 0 && a != 0) ? (10'(1) << s) : 10'h0;
                        cfg(ev, a[0]);
                        fire(s);
                        chk({src_tag(s, m[0]), " R7 R8 flags"}, 32'(flags), 32'(exp));
                        chk({src_tag(s, m[0]), " R11 req"}, 32'(wake_req), 32'(exp != 0));
                        idle();
                    end
                end
            end
        end

        // R5 restart after a low sample
        opt_rxdis = 1'b0;
        cfg(6'h3f, 1'b1);
        pin_b = 1'b1; cyc(4);
        repeat (HOLD - 1) tk();
        cyc(3);
        chk("R5 early", 32'(flags), 0);
        pin_b = 1'b0; cyc(4); tk();
        pin_b = 1'b1; cyc(4);
        repeat (HOLD - 1) tk();
        cyc(3);
        chk("R5 restarted", 32'(flags), 0);
        tk(); cyc(3);
        chk("R5 complete", 32'(flags), 32'(10'(1) << 4));
        idle();

        // R4 falling edge ignored
        cfg(6'h3f, 1'b0);
        pin_a = 1'b1; cyc(5);
        cfg(6'h3f, 1'b1);
        pin_a = 1'b0; cyc(5);
        chk("R4 falling", 32'(flags), 0);
        idle();

        // R10 sticky and selective clear
        fire(0);
        cyc(20);
        chk("R10 held", 32'(flags), 1);
        clr(10'h004);
        chk("R10 other clear", 32'(flags), 1);
        clr(10'h001);
        chk("R10 cleared", 32'(flags), 0);

        // R11 request follows the enable of a set flag
        fire(3);
        cfg(6'h37, 1'b1);
        chk("R11 flag kept", 32'(flags), 32'h008);
        chk("R11 masked req", 32'(wake_req), 0);
        cfg(6'h3f, 1'b1);
        chk("R11 unmasked req", 32'(wake_req), 1);
        idle();

        // R9 fixed causes ignore enable and arm
        cfg(6'h00, 1'b0);
        for (int k = 0; k < 4; k++) begin
            fixed_ev = 4'(1) << k; cyc(1); fixed_ev = '0; cyc(2);
            chk("R9 fixed flag", 32'(flags), 32'(10'(1) << (6 + k)));
            chk("R9 R11 fixed req", 32'(wake_req), 1);
            clr('1);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule